// File: doc/BRIEF.md
# Reconfigurable Grid Neighbour Network

This block links a rows-by-columns array of processing elements so that each one can hand a 32-bit word to an adjacent element. Every element has its own router. A router keeps a one-word inbox for each of the eight compass directions it can receive from. A sender presents a word and a 3-bit direction code. The word moves in one hop into the matching inbox of the neighbour. The receiver selects a direction and reads back what arrived from there.

The link pattern can be changed while the array runs. In mesh mode the edges of the grid are hard boundaries. Torus mode wraps the edges around. X-net mode adds the four diagonal links and also wraps. A request to change the topology is held until the network is quiet, so a word that is in flight is never re-routed or lost. A full inbox makes its sender stall rather than overwrite the word already there.

Top module: `grid_nbr_net`

## Requirements
- R1: After reset the topology is torus (code 1) and every inbox is empty: for every element and every read direction, rd_valid is 0 and rd_data is zero.
- R2: Direction codes are 0 north, 1 east, 2 west, 3 south, 4 northeast, 5 northwest, 6 southeast, 7 southwest. Element index is row*COLS+column, with row 0 at the north and column 0 at the west. An accepted write in direction d lands in the receiver's inbox for the opposite direction (0/3, 1/2, 4/7 and 5/6 are the opposite pairs).
- R3: A write that is accepted at a clock edge can be read at the receiver in the cycle after that edge. No inbox becomes full without a write in the cycle before.
- R4: In torus mode the row and column neighbours wrap around modulo ROWS and COLS.
- R5: In mesh mode a write that would cross the grid edge raises wr_err in the same cycle and is dropped. A read toward a missing neighbour returns rd_valid 0 and zero data.
- R6: The diagonal codes 4 to 7 are accepted only in X-net mode (topology code 2), where they wrap at the edges like torus links. In mesh or torus mode they raise wr_err and store nothing.
- R7: When the target inbox is full, wr_stall is high, wr_err is low, the new word is not stored, and the word already held is kept.
- R8: Topology codes are 0 mesh, 1 torus, 2 X-net. Code 3 on a request is ignored. A request (topo_set with topo_req) takes effect at the first clock edge at which no inbox is full and no write is presented. Until then the request is held, and a later request replaces it. The topology never changes while a transfer is pending.
- R9: Asserting rd_en empties the selected inbox at the clock edge, so each word is read exactly once. A full inbox stays full until it is read.
- R10: Inboxes of the same element are independent: words from different neighbours, written in the same cycle, are all held and each can be read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| topo_set | input | 1 | Strobe that requests a topology change |
| topo_req | input | 2 | Requested topology (0 mesh, 1 torus, 2 X-net) |
| topo_cur | output | 2 | Topology in force |
| wr_en | input | ROWS*COLS | Per element: present a word to send |
| wr_dir | input | 3*ROWS*COLS | Per element: direction code of the send |
| wr_data | input | 32*ROWS*COLS | Per element: word to send |
| wr_stall | output | ROWS*COLS | Per element: target inbox full, send not taken |
| wr_err | output | ROWS*COLS | Per element: no link in that direction, send dropped |
| rd_en | input | ROWS*COLS | Per element: consume the selected inbox |
| rd_dir | input | 3*ROWS*COLS | Per element: direction to read from |
| rd_data | output | 32*ROWS*COLS | Per element: word held from that direction, zero if none |
| rd_valid | output | ROWS*COLS | Per element: selected inbox holds a word |

## Verification
The bench builds the network as 2 rows by 4 columns. With that shape every element sits on a north or south edge. The north and south neighbours are then the same element under wrap, yet they must still fill separate inboxes. Row wrap, column wrap and diagonal wrap through a corner can all be checked with a few elements. The small count also lets the bench sweep every inbox of every element after each dropped write. Further tests cover a held topology request against a full inbox, a stall against an occupied inbox, and two neighbours writing into one element in the same cycle.

// File: rtl/gnn_pkg.sv
`timescale 1ns/1ps
package gnn_pkg;

  typedef enum logic [1:0] {
    TOPO_MESH  = 2'd0,
    TOPO_TORUS = 2'd1,
    TOPO_XNET  = 2'd2
  } topo_e;

  localparam int NDIR  = 8;
  localparam int DIR_W = 3;

  // Row step for a direction code (north is toward row 0).
  function automatic int dir_dr(input int k);
    case (k)
      0, 4, 5: dir_dr = -1;
      3, 6, 7: dir_dr = 1;
      default: dir_dr = 0;
    endcase
  endfunction

  // Column step for a direction code (east is toward higher columns).
  function automatic int dir_dc(input int k);
    case (k)
      1, 4, 6: dir_dc = 1;
      2, 5, 7: dir_dc = -1;
      default: dir_dc = 0;
    endcase
  endfunction

  function automatic int opp_dir(input int k);
    opp_dir = (k < 4) ? (3 - k) : (11 - k);
  endfunction

  // Wrapped neighbour index of element p in direction k.
  function automatic int nbr_idx(input int p, input int k, input int rows, input int cols);
    int r;
    int c;
    r = (p / cols + dir_dr(k) + rows) % rows;
    c = (p % cols + dir_dc(k) + cols) % cols;
    nbr_idx = r * cols + c;
  endfunction

  // True when the step leaves the grid (a wrap would be needed).
  function automatic bit off_grid(input int p, input int k, input int rows, input int cols);
    int r;
    int c;
    r = p / cols + dir_dr(k);
    c = p % cols + dir_dc(k);
    off_grid = (r < 0) || (r >= rows) || (c < 0) || (c >= cols);
  endfunction

endpackage

// File: rtl/gnn_rx_slot.sv
`timescale 1ns/1ps
module gnn_rx_slot #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          clr,
  output logic          valid,
  output logic [DW-1:0] data
);

  logic          v_q, v_d;
  logic [DW-1:0] d_q, d_d;

  always_comb begin
    v_d = v_q;
    d_d = d_q;
    if (load) begin
      v_d = 1'b1;
      d_d = load_data;
    end else if (clr) begin
      v_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      d_q <= '0;
    end else begin
      v_q <= v_d;
      d_q <= d_d;
    end
  end

  assign valid = v_q;
  assign data  = d_q;

endmodule

// File: rtl/gnn_topo_ctrl.sv
`timescale 1ns/1ps
module gnn_topo_ctrl
  import gnn_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set,
  input  logic [1:0] req,
  input  logic       busy,
  output topo_e      topo
);

  topo_e topo_q, topo_d;
  topo_e hold_t, hold_t_d;
  logic  hold_v, hold_v_d;
  logic  req_ok;
  logic  want_v;
  topo_e want_t;

  assign req_ok = set && (req != 2'd3);
  assign want_v = req_ok || hold_v;
  assign want_t = req_ok ? topo_e'(req) : hold_t;

  always_comb begin
    topo_d   = topo_q;
    hold_v_d = hold_v;
    hold_t_d = hold_t;
    if (want_v && !busy) begin
      topo_d   = want_t;
      hold_v_d = 1'b0;
    end else if (req_ok) begin
      hold_v_d = 1'b1;
      hold_t_d = topo_e'(req);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      topo_q <= TOPO_TORUS;
      hold_v <= 1'b0;
      hold_t <= TOPO_TORUS;
    end else begin
      topo_q <= topo_d;
      hold_v <= hold_v_d;
      hold_t <= hold_t_d;
    end
  end

  assign topo = topo_q;

endmodule

// File: rtl/gnn_router.sv
`timescale 1ns/1ps
module gnn_router
  import gnn_pkg::*;
#(
  parameter int P    = 0,
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int DW   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  topo_e              topo,
  input  logic [NDIR-1:0]    put,
  input  logic [NDIR*DW-1:0] put_data,
  output logic [NDIR-1:0]    full,
  output logic [NDIR-1:0]    link_ok,
  input  logic               rd_en,
  input  logic [DIR_W-1:0]   rd_dir,
  output logic [DW-1:0]      rd_data,
  output logic               rd_valid,
  input  logic               wr_en,
  input  logic [DIR_W-1:0]   wr_dir,
  input  logic [NDIR-1:0]    tgt_full,
  output logic               wr_stall,
  output logic               wr_err
);

  logic [DW-1:0] slot_data [NDIR];

  for (genvar k = 0; k < NDIR; k++) begin : g_dir
    localparam bit EDGE = off_grid(P, k, ROWS, COLS);
    localparam bit DIAG = (k >= 4);

    assign link_ok[k] = (!DIAG || (topo == TOPO_XNET)) &&
                        !((topo == TOPO_MESH) && EDGE);

    gnn_rx_slot #(.DW(DW)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (put[k]),
      .load_data (put_data[k*DW +: DW]),
      .clr       (rd_en && (rd_dir == DIR_W'(k))),
      .valid     (full[k]),
      .data      (slot_data[k])
    );
  end

  assign rd_valid = full[rd_dir] && link_ok[rd_dir];
  assign rd_data  = rd_valid ? slot_data[rd_dir] : '0;

  assign wr_err   = wr_en && !link_ok[wr_dir];
  assign wr_stall = wr_en && link_ok[wr_dir] && tgt_full[wr_dir];

endmodule

// File: rtl/grid_nbr_net.sv
`timescale 1ns/1ps
module grid_nbr_net
  import gnn_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int DW   = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        topo_set,
  input  logic [1:0]                  topo_req,
  output logic [1:0]                  topo_cur,
  input  logic [ROWS*COLS-1:0]        wr_en,
  input  logic [ROWS*COLS*DIR_W-1:0]  wr_dir,
  input  logic [ROWS*COLS*DW-1:0]     wr_data,
  output logic [ROWS*COLS-1:0]        wr_stall,
  output logic [ROWS*COLS-1:0]        wr_err,
  input  logic [ROWS*COLS-1:0]        rd_en,
  input  logic [ROWS*COLS*DIR_W-1:0]  rd_dir,
  output logic [ROWS*COLS*DW-1:0]     rd_data,
  output logic [ROWS*COLS-1:0]        rd_valid
);

  localparam int N     = ROWS * COLS;
  localparam int SLOTS = N * NDIR;

  topo_e               topo;
  logic                busy;
  logic [SLOTS-1:0]    full_all;
  logic [SLOTS-1:0]    link_all;
  logic [SLOTS-1:0]    put_all;
  logic [SLOTS-1:0]    tgt_full_all;
  logic [SLOTS*DW-1:0] put_data_all;

  assign busy     = (|full_all) || (|wr_en);
  assign topo_cur = topo;

  gnn_topo_ctrl u_topo (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (topo_set),
    .req   (topo_req),
    .busy  (busy),
    .topo  (topo)
  );

  for (genvar p = 0; p < N; p++) begin : g_pe
    for (genvar k = 0; k < NDIR; k++) begin : g_link
      localparam int SRC = nbr_idx(p, k, ROWS, COLS);
      localparam int OPP = opp_dir(k);
      localparam int J   = p * NDIR + k;

      // Inbox k of element p is fed by its neighbour in direction k,
      // which sends toward the opposite direction.
      assign put_all[J] = wr_en[SRC] &&
                          (wr_dir[SRC*DIR_W +: DIR_W] == DIR_W'(OPP)) &&
                          link_all[J] && !full_all[J];
      assign put_data_all[J*DW +: DW] = wr_data[SRC*DW +: DW];
      // Seen from sender p: the inbox it targets in direction k.
      assign tgt_full_all[J] = full_all[SRC*NDIR + OPP];
    end

    gnn_router #(.P(p), .ROWS(ROWS), .COLS(COLS), .DW(DW)) u_rtr (
      .clk      (clk),
      .rst_n    (rst_n),
      .topo     (topo),
      .put      (put_all[p*NDIR +: NDIR]),
      .put_data (put_data_all[p*NDIR*DW +: NDIR*DW]),
      .full     (full_all[p*NDIR +: NDIR]),
      .link_ok  (link_all[p*NDIR +: NDIR]),
      .rd_en    (rd_en[p]),
      .rd_dir   (rd_dir[p*DIR_W +: DIR_W]),
      .rd_data  (rd_data[p*DW +: DW]),
      .rd_valid (rd_valid[p]),
      .wr_en    (wr_en[p]),
      .wr_dir   (wr_dir[p*DIR_W +: DIR_W]),
      .tgt_full (tgt_full_all[p*NDIR +: NDIR]),
      .wr_stall (wr_stall[p]),
      .wr_err   (wr_err[p])
    );
  end

endmodule

// File: rtl/gnn_checker.sv
`timescale 1ns/1ps
module gnn_checker #(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [1:0]                 topo_cur,
  input logic [ROWS*COLS-1:0]       wr_en,
  input logic [ROWS*COLS*3-1:0]     wr_dir,
  input logic [ROWS*COLS-1:0]       wr_err,
  input logic [ROWS*COLS-1:0]       rd_en,
  input logic [ROWS*COLS*3-1:0]     rd_dir,
  input logic [ROWS*COLS*8-1:0]     full_all
);

  localparam int N = ROWS * COLS;

  assert_topo_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    topo_cur != 2'd3);

  assert_topo_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (topo_cur != $past(topo_cur)) |-> (($past(full_all) == '0) && ($past(wr_en) == '0)));

  assert_fill_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(full_all) > $past($countones(full_all))) |-> $past(|wr_en));

  for (genvar p = 0; p < N; p++) begin : g_pe
    assert_diag_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en[p] && wr_dir[p*3+2] && (topo_cur != 2'd2)) |-> wr_err[p]);

    for (genvar k = 0; k < 8; k++) begin : g_slot
      assert_hold_until_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(full_all[p*8+k]) && !$past(rd_en[p] && (rd_dir[p*3 +: 3] == 3'(k))))
          |-> full_all[p*8+k]);
    end
  end

endmodule

bind grid_nbr_net gnn_checker #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .topo_cur (topo_cur),
  .wr_en    (wr_en),
  .wr_dir   (wr_dir),
  .wr_err   (wr_err),
  .rd_en    (rd_en),
  .rd_dir   (rd_dir),
  .full_all (full_all)
);

// File: tb/grid_nbr_net_tb_top.sv
`timescale 1ns/1ps
module grid_nbr_net_tb_top;

  localparam int ROWS = 2;
  localparam int COLS = 4;
  localparam int N    = ROWS * COLS;
  localparam int DW   = 32;
  localparam int NV   = 15;

  // Vector: [50:49] topo, [48:46] src, [45:43] dir, [42:11] data,
  //         [10:8] dst, [7:5] read dir, [4] expect error, [3:0] requirement
  localparam logic [50:0] VEC [NV] = '{
    {2'd1, 3'd5, 3'd1, 32'hA1A1_0001, 3'd6, 3'd2, 1'b0, 4'd2},  // R2 east
    {2'd1, 3'd5, 3'd0, 32'hA1A1_0002, 3'd1, 3'd3, 1'b0, 4'd2},  // R2 north
    {2'd1, 3'd0, 3'd2, 32'hB2B2_0003, 3'd3, 3'd1, 1'b0, 4'd4},  // R4 column wrap
    {2'd1, 3'd0, 3'd0, 32'hB2B2_0004, 3'd4, 3'd3, 1'b0, 4'd4},  // R4 row wrap
    {2'd1, 3'd7, 3'd1, 32'hB2B2_0005, 3'd4, 3'd2, 1'b0, 4'd4},  // R4 east wrap
    {2'd1, 3'd5, 3'd4, 32'hC3C3_0006, 3'd0, 3'd0, 1'b1, 4'd6},  // R6 diag in torus
    {2'd0, 3'd0, 3'd2, 32'hD4D4_0007, 3'd0, 3'd0, 1'b1, 4'd5},  // R5 west edge
    {2'd0, 3'd7, 3'd3, 32'hD4D4_0008, 3'd0, 3'd0, 1'b1, 4'd5},  // R5 south edge
    {2'd0, 3'd5, 3'd2, 32'hE5E5_0009, 3'd4, 3'd1, 1'b0, 4'd2},  // R2 west in mesh
    {2'd0, 3'd2, 3'd3, 32'hE5E5_000A, 3'd6, 3'd0, 1'b0, 4'd2},  // R2 south in mesh
    {2'd2, 3'd0, 3'd4, 32'hF6F6_000B, 3'd5, 3'd7, 1'b0, 4'd6},  // R6 NE wrap
    {2'd2, 3'd5, 3'd7, 32'hF6F6_000C, 3'd0, 3'd4, 1'b0, 4'd6},  // R6 SW wrap
    {2'd2, 3'd3, 3'd6, 32'hF6F6_000D, 3'd4, 3'd5, 1'b0, 4'd6},  // R6 SE wrap
    {2'd2, 3'd6, 3'd5, 32'hF6F6_000E, 3'd1, 3'd6, 1'b0, 4'd6},  // R6 NW
    {2'd2, 3'd1, 3'd3, 32'h0707_000F, 3'd5, 3'd0, 1'b0, 4'd3}   // R3 latency
  };

  logic              clk;
  logic              rst_n;
  logic              topo_set;
  logic [1:0]        topo_req;
  logic [1:0]        topo_cur;
  logic [N-1:0]      wr_en;
  logic [N*3-1:0]    wr_dir;
  logic [N*DW-1:0]   wr_data;
  logic [N-1:0]      wr_stall;
  logic [N-1:0]      wr_err;
  logic [N-1:0]      rd_en;
  logic [N*3-1:0]    rd_dir;
  logic [N*DW-1:0]   rd_data;
  logic [N-1:0]      rd_valid;

  int  n_checks;
  int  n_fails;
  bit  done;

  grid_nbr_net #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .topo_set (topo_set),
    .topo_req (topo_req),
    .topo_cur (topo_cur),
    .wr_en    (wr_en),
    .wr_dir   (wr_dir),
    .wr_data  (wr_data),
    .wr_stall (wr_stall),
    .wr_err   (wr_err),
    .rd_en    (rd_en),
    .rd_dir   (rd_dir),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input int p, input logic [2:0] d, input logic [31:0] v);
    wr_en[p]             = 1'b1;
    wr_dir[p*3 +: 3]     = d;
    wr_data[p*DW +: DW]  = v;
  endtask

  task automatic set_topo(input logic [1:0] t);
    @(negedge clk);
    topo_set = 1'b1;
    topo_req = t;
    @(negedge clk);
    topo_set = 1'b0;
    #1;
  endtask

  // Returns the number of full inboxes seen through the read ports.
  task automatic sweep(output int cnt, output logic [31:0] orsum);
    cnt   = 0;
    orsum = '0;
    for (int d = 0; d < 8; d++) begin
      for (int p = 0; p < N; p++) rd_dir[p*3 +: 3] = 3'(d);
      #0.1;
      cnt += $countones(rd_valid);
      for (int p = 0; p < N; p++) orsum |= rd_data[p*DW +: DW];
    end
    rd_dir = '0;
    @(negedge clk);
  endtask

  initial begin
    int          cnt;
    logic [31:0] orsum;
    n_checks = 0;
    n_fails  = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    topo_set = 1'b0;
    topo_req = 2'd0;
    wr_en    = '0;
    wr_dir   = '0;
    wr_data  = '0;
    rd_en    = '0;
    rd_dir   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(topo_cur == 2'd1, "R1 reset topology", 32'(topo_cur), 32'd1);
    sweep(cnt, orsum);
    chk(cnt == 0, "R1 reset inboxes empty", 32'(cnt), 32'd0);
    chk(orsum == 0, "R1 reset read data zero", orsum, 32'd0);

    // Table of single transfers
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  t;
      int          src;
      logic [2:0]  d;
      logic [31:0] v;
      int          dst;
      logic [2:0]  rdir;
      bit          e;
      string       tag;
      t    = VEC[i][50:49];
      src  = int'(VEC[i][48:46]);
      d    = VEC[i][45:43];
      v    = VEC[i][42:11];
      dst  = int'(VEC[i][10:8]);
      rdir = VEC[i][7:5];
      e    = VEC[i][4];
      tag  = $sformatf("R%0d vector %0d", VEC[i][3:0], i);
      if (topo_cur != t) begin
        set_topo(t);
        chk(topo_cur == t, "R8 idle topology change", 32'(topo_cur), 32'(t));
      end
      @(negedge clk);
      send(src, d, v);
      #1;
      chk(wr_err[src] == e, tag, 32'(wr_err[src]), 32'(e));
      chk(wr_stall[src] == 1'b0, tag, 32'(wr_stall[src]), 32'd0);
      @(negedge clk);
      wr_en = '0;
      if (!e) begin
        rd_dir[dst*3 +: 3] = rdir;
        #1;
        chk(rd_valid[dst] == 1'b1, tag, 32'(rd_valid[dst]), 32'd1);
        chk(rd_data[dst*DW +: DW] == v, tag, rd_data[dst*DW +: DW], v);
        rd_en[dst] = 1'b1;
        @(negedge clk);
        rd_en = '0;
        #1;
        chk(rd_valid[dst] == 1'b0, "R9 read consumes word", 32'(rd_valid[dst]), 32'd0);
        rd_dir = '0;
        @(negedge clk);
      end else begin
        sweep(cnt, orsum);
        chk(cnt == 0, {tag, " dropped word stored"}, 32'(cnt), 32'd0);
      end
    end

    // R5: read toward a missing neighbour in mesh
    set_topo(2'd0);
    chk(topo_cur == 2'd0, "R8 switch to mesh", 32'(topo_cur), 32'd0);
    rd_dir[0*3 +: 3] = 3'd2;
    #0.5;
    chk(rd_valid[0] == 1'b0, "R5 missing neighbour valid", 32'(rd_valid[0]), 32'd0);
    chk(rd_data[0 +: DW] == '0, "R5 missing neighbour data", rd_data[0 +: DW], 32'd0);
    rd_dir = '0;

    // R3 + R7 + R8: stall on a full inbox, deferred topology change
    set_topo(2'd1);
    chk(topo_cur == 2'd1, "R8 back to torus", 32'(topo_cur), 32'd1);
    @(negedge clk);
    send(5, 3'd1, 32'h1111_AAAA);
    @(negedge clk);
    send(5, 3'd1, 32'h2222_BBBB);
    topo_set = 1'b1;
    topo_req = 2'd0;
    #1;
    chk(wr_stall[5] == 1'b1, "R7 stall on full inbox", 32'(wr_stall[5]), 32'd1);
    chk(wr_err[5] == 1'b0, "R7 no error on stall", 32'(wr_err[5]), 32'd0);
    @(negedge clk);
    wr_en    = '0;
    topo_set = 1'b0;
    @(negedge clk);
    chk(topo_cur == 2'd1, "R8 change held while pending", 32'(topo_cur), 32'd1);
    rd_dir[6*3 +: 3] = 3'd2;
    #1;
    chk(rd_data[6*DW +: DW] == 32'h1111_AAAA, "R7 first word kept", rd_data[6*DW +: DW], 32'h1111_AAAA);
    rd_en[6] = 1'b1;
    @(negedge clk);
    rd_en = '0;
    #1;
    chk(rd_valid[6] == 1'b0, "R7 stalled word not stored", 32'(rd_valid[6]), 32'd0);
    @(negedge clk);
    chk(topo_cur == 2'd0, "R8 held change applied when quiet", 32'(topo_cur), 32'd0);
    rd_dir = '0;

    // R8: code 3 ignored
    set_topo(2'd3);
    @(negedge clk);
    chk(topo_cur == 2'd0, "R8 code 3 ignored", 32'(topo_cur), 32'd0);

    // R10: two neighbours into one element in the same cycle
    set_topo(2'd1);
    @(negedge clk);
    send(1, 3'd3, 32'h5151_0001);
    send(4, 3'd1, 32'h5454_0002);
    @(negedge clk);
    wr_en = '0;
    rd_dir[5*3 +: 3] = 3'd0;
    #0.5;
    chk(rd_data[5*DW +: DW] == 32'h5151_0001, "R10 word from north", rd_data[5*DW +: DW], 32'h5151_0001);
    rd_dir[5*3 +: 3] = 3'd2;
    #0.5;
    chk(rd_data[5*DW +: DW] == 32'h5454_0002, "R10 word from west", rd_data[5*DW +: DW], 32'h5454_0002);
    @(negedge clk);
    rd_en[5] = 1'b1;
    rd_dir[5*3 +: 3] = 3'd0;
    @(negedge clk);
    rd_dir[5*3 +: 3] = 3'd2;
    @(negedge clk);
    rd_en = '0;
    rd_dir = '0;
    sweep(cnt, orsum);
    chk(cnt == 0, "R9 all inboxes drained", 32'(cnt), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
    end
  end

endmodule